// File: doc/BRIEF.md
# Sign-Magnitude Saturating Multiply-Accumulate Unit

This block multiplies a coefficient by a data sample and folds the product into a running sum. All three quantities are kept as a sign bit plus an unsigned magnitude.

- The coefficient magnitude is 8 bits in 1.7 format.
- The sample magnitude is 8 bits in 2.6 format.
- Their product is formed by an unsigned multiplier. It is 16 bits in 3.13 format and lines up with the accumulator magnitude bit for bit.

The accumulator adds in sign-magnitude terms:

- **Equal signs:** the magnitudes are added. A carry out of the top bit pins the magnitude to all ones and keeps the sign.
- **Unequal signs:** both differences are formed. The one with no borrow becomes the magnitude, and the sign follows the larger operand.

A synchronous clear resets the sum between filter taps or packets. An enable lets the caller skip cycles without disturbing the sum. The result is registered, so it appears one clock after the operands are presented. Rounding to an output width is left to the consumer.

Top module: `sm_mac`

## Requirements
- R1: After synchronous reset the accumulator reads sign 0, magnitude 0 (+0).
- R2: `clr` high sets the accumulator to +0 on the next edge, whatever `acc_en` is.
- R3: With `clr` and `acc_en` low, the accumulator sign and magnitude do not change, whatever the operand inputs are.
- R4: The product magnitude is the unsigned product of `coef_mag` and `samp_mag`, added at bit 0 of the accumulator magnitude. For example, 0x80 (1.0) times 0x40 (1.0) adds 0x2000 (1.0 in 3.13).
- R5: The product sign is `coef_sign` XOR `samp_sign`, where sign 1 means negative.
- R6: When the accumulator and the product have the same sign, the new magnitude is their sum and the sign is kept.
- R7: When the signs differ, the new magnitude is the absolute difference and the sign is that of the operand with the larger magnitude.
- R8: A same-sign sum that exceeds the magnitude range saturates to 0xFFFF and keeps the sign. Later opposite-sign terms subtract from 0xFFFF.
- R9: A zero result always carries sign 0; negative zero never appears at the output. This includes a zero product with a negative sign.
- R10: Adding +1.0 to an accumulator holding -1.96875 gives -0.96875 (sign 1, magnitude 0x1F00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear accumulator to +0 (priority over enable) |
| acc_en | input | 1 | Accumulate this cycle's product |
| coef_sign | input | 1 | Coefficient sign (1 = negative) |
| coef_mag | input | 8 | Coefficient magnitude, 1.7 format |
| samp_sign | input | 1 | Sample sign (1 = negative) |
| samp_mag | input | 8 | Sample magnitude, 2.6 format |
| acc_sign | output | 1 | Accumulator sign (1 = negative) |
| acc_mag | output | 16 | Accumulator magnitude, 3.13 format |

## Verification
The bench drives the crossing case where a small positive term meets a larger negative sum. A design that subtracted in only one direction would return a wrapped magnitude such as 0xE100 instead of 0x1F00.

It pushes same-sign sums of near-full-scale products past the range in both signs. A design without saturation would wrap to a small value; one that handled the sign wrongly would flip it.

Exact cancellations and zero products with a negative sign expose a design that leaves negative zero on the output. A clear asserted together with the enable exposes a design that gives the enable priority.

A long run of mixed-sign random operands, compared against an integer model, covers the remaining ordering of larger and smaller operands.

// File: rtl/sm_mac_pkg.sv
package sm_mac_pkg;

    // Default operand and accumulator widths
    localparam int unsigned COEF_MAG_W = 8;
    localparam int unsigned SAMP_MAG_W = 8;
    localparam int unsigned ACC_MAG_W  = 16;

    // Which arithmetic path the adder takes this cycle
    typedef enum logic [1:0] {
        PATH_SUM    = 2'd0,
        PATH_A_MINUS_B = 2'd1,
        PATH_B_MINUS_A = 2'd2
    } sm_path_e;

    // A zero magnitude is always forced to a positive sign
    function automatic logic sm_fix_sign(input logic sign, input logic is_zero);
        return sign & ~is_zero;
    endfunction

endpackage

// File: rtl/sm_mult.sv
module sm_mult #(
    parameter int unsigned A_W = 8,
    parameter int unsigned B_W = 8,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic           a_sign,
    input  logic [A_W-1:0] a_mag,
    input  logic           b_sign,
    input  logic [B_W-1:0] b_mag,
    output logic           p_sign,
    output logic [P_W-1:0] p_mag
);
    import sm_mac_pkg::*;

    logic [P_W-1:0] raw_prod;

    // Unsigned magnitude product; sign handled separately
    always_comb begin
        raw_prod = P_W'(a_mag) * P_W'(b_mag);
    end

    assign p_mag  = raw_prod;
    assign p_sign = sm_fix_sign(a_sign ^ b_sign, raw_prod == '0);

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
    parameter int unsigned W = 16
) (
    input  logic         a_sign,
    input  logic [W-1:0] a_mag,
    input  logic         b_sign,
    input  logic [W-1:0] b_mag,
    output logic         r_sign,
    output logic [W-1:0] r_mag,
    output logic         r_sat
);
    import sm_mac_pkg::*;

    logic [W:0]  sum_ext;
    logic [W:0]  diff_ab;
    logic [W:0]  diff_ba;
    sm_path_e    path;
    logic        pre_sign;
    logic [W-1:0] pre_mag;

    // Compute every candidate in parallel
    assign sum_ext = {1'b0, a_mag} + {1'b0, b_mag};
    assign diff_ab = {1'b0, a_mag} - {1'b0, b_mag};
    assign diff_ba = {1'b0, b_mag} - {1'b0, a_mag};

    // Select a path: equal signs add, else keep the borrow-free difference
    always_comb begin
        if (a_sign == b_sign)
            path = PATH_SUM;
        else if (!diff_ab[W])
            path = PATH_A_MINUS_B;
        else
            path = PATH_B_MINUS_A;
    end

    always_comb begin
        r_sat = 1'b0;
        case (path)
            PATH_SUM: begin
                pre_sign = a_sign;
                r_sat    = sum_ext[W];
                pre_mag  = sum_ext[W] ? {W{1'b1}} : sum_ext[W-1:0];
            end
            PATH_A_MINUS_B: begin
                pre_sign = a_sign;
                pre_mag  = diff_ab[W-1:0];
            end
            default: begin
                pre_sign = b_sign;
                pre_mag  = diff_ba[W-1:0];
            end
        endcase
    end

    assign r_mag  = pre_mag;
    assign r_sign = sm_fix_sign(pre_sign, pre_mag == '0);

endmodule

// File: rtl/sm_mac.sv
module sm_mac #(
    parameter int unsigned COEF_W = sm_mac_pkg::COEF_MAG_W,
    parameter int unsigned SAMP_W = sm_mac_pkg::SAMP_MAG_W,
    parameter int unsigned ACC_W  = sm_mac_pkg::ACC_MAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc_en,
    input  logic              coef_sign,
    input  logic [COEF_W-1:0] coef_mag,
    input  logic              samp_sign,
    input  logic [SAMP_W-1:0] samp_mag,
    output logic              acc_sign,
    output logic [ACC_W-1:0]  acc_mag
);
    localparam int unsigned PROD_W = COEF_W + SAMP_W;
    localparam int unsigned PAD_W  = ACC_W - PROD_W;

    logic              p_sign;
    logic [PROD_W-1:0] p_mag;
    logic [ACC_W-1:0]  p_ext;
    logic              nx_sign;
    logic [ACC_W-1:0]  nx_mag;
    logic              nx_sat;

    sm_mult #(.A_W(COEF_W), .B_W(SAMP_W)) u_mult (
        .a_sign (coef_sign),
        .a_mag  (coef_mag),
        .b_sign (samp_sign),
        .b_mag  (samp_mag),
        .p_sign (p_sign),
        .p_mag  (p_mag)
    );

    // Product is aligned with the accumulator at bit 0
    generate
        if (PAD_W == 0) begin : g_no_pad
            assign p_ext = p_mag;
        end else begin : g_pad
            assign p_ext = {{PAD_W{1'b0}}, p_mag};
        end
    endgenerate

    sm_addsub #(.W(ACC_W)) u_add (
        .a_sign (acc_sign),
        .a_mag  (acc_mag),
        .b_sign (p_sign),
        .b_mag  (p_ext),
        .r_sign (nx_sign),
        .r_mag  (nx_mag),
        .r_sat  (nx_sat)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_sign <= 1'b0;
            acc_mag  <= '0;
        end else if (acc_en) begin
            acc_sign <= nx_sign;
            acc_mag  <= nx_mag;
        end
    end

    // R2: clear wins over enable and yields +0
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_mag == '0 && !acc_sign));

    // R3: idle cycle leaves the sum untouched
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !acc_en) |=> ($stable(acc_mag) && $stable(acc_sign)));

    // R9: no negative zero on the output
    a_r9_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_mag == '0) |-> !acc_sign);

    // R8: a same-sign overflow pins the magnitude and keeps the sign
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clr && acc_en && nx_sat) |=> (&acc_mag && acc_sign == $past(acc_sign)));

    // R5: starting from zero, the new sign is the XOR of operand signs
    a_r5_prod_sign: assert property (@(posedge clk) disable iff (rst)
        (!clr && acc_en && acc_mag == '0 && p_mag != '0)
        |=> acc_sign == $past(coef_sign ^ samp_sign));

    // R7: differing signs with a larger product take the product's sign
    a_r7_larger_sign: assert property (@(posedge clk) disable iff (rst)
        (!clr && acc_en && acc_sign != p_sign && p_ext > acc_mag)
        |=> acc_sign == $past(p_sign));

endmodule

// File: tb/test_sm_mac.sv
module test_sm_mac;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        acc_en = 1'b0;
    logic        coef_sign = 1'b0;
    logic [7:0]  coef_mag = '0;
    logic        samp_sign = 1'b0;
    logic [7:0]  samp_mag = '0;
    logic        acc_sign;
    logic [15:0] acc_mag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic        s;
        logic [15:0] m;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state
    bit m_s = 1'b0;
    int m_m = 0;

    always #5 clk = ~clk;

    sm_mac i_sm_mac (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .acc_en    (acc_en),
        .coef_sign (coef_sign),
        .coef_mag  (coef_mag),
        .samp_sign (samp_sign),
        .samp_mag  (samp_mag),
        .acc_sign  (acc_sign),
        .acc_mag   (acc_mag)
    );

    task automatic check(input string tag, input logic s, input logic [15:0] m,
                         input logic es, input logic [15:0] em);
        n_tests++;
        if (s !== es || m !== em) begin
            n_fail++;
            $display("FAIL %s: got sign=%0b mag=0x%04h, expected sign=%0b mag=0x%04h",
                     tag, s, m, es, em);
        end
    endtask

    // Driver: apply one operation and push the expected result
    task automatic drive(input bit c, input bit e, input bit cs, input int cm,
                         input bit ss, input int sm, input string tag);
        int  prod;
        bit  ps;
        exp_t it;
        @(negedge clk);
        clr = c; acc_en = e;
        coef_sign = cs; coef_mag = 8'(cm);
        samp_sign = ss; samp_mag = 8'(sm);
        prod = cm * sm;
        ps   = (prod == 0) ? 1'b0 : (cs ^ ss);
        if (c) begin
            m_s = 1'b0; m_m = 0;
        end else if (e) begin
            if (m_s == ps) begin
                m_m = m_m + prod;
                if (m_m > 65535) m_m = 65535;
            end else if (m_m >= prod) begin
                m_m = m_m - prod;
            end else begin
                m_m = prod - m_m;
                m_s = ps;
            end
            if (m_m == 0) m_s = 1'b0;
        end
        it.s = m_s; it.m = 16'(m_m); it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: one result per clock, sampled shortly after the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(it.tag, acc_sign, acc_mag, it.s, it.m);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", acc_sign, acc_mag, 1'b0, 16'h0000);

        drive(0, 1, 0, 8'h80, 0, 8'h40, "R4 1.0*1.0");
        drive(0, 1, 0, 8'h80, 0, 8'h40, "R6 same sign add");
        drive(1, 1, 0, 8'h80, 0, 8'h40, "R2 clear beats enable");
        drive(0, 1, 1, 8'h80, 0, 8'h7E, "R5 neg product");
        drive(0, 1, 0, 8'h80, 0, 8'h40, "R10 +1.0 onto -1.96875");
        drive(0, 0, 1, 8'hFF, 0, 8'hFF, "R3 hold");
        drive(0, 1, 0, 8'h80, 0, 8'h7E, "R7 larger product wins");
        drive(0, 1, 1, 8'h10, 1, 8'h10, "R5 neg*neg positive");
        drive(1, 0, 0, 0, 0, 0, "R2 clear");
        drive(0, 1, 1, 8'h00, 0, 8'h40, "R9 zero product negative sign");
        drive(0, 1, 0, 8'h40, 0, 8'h40, "R6 add");
        drive(0, 1, 1, 8'h40, 0, 8'h40, "R9 exact cancel");
        drive(0, 1, 0, 8'hFF, 0, 8'hFF, "R8 pos step");
        drive(0, 1, 0, 8'hFF, 0, 8'hFF, "R8 pos saturate");
        drive(0, 1, 0, 8'hFF, 0, 8'hFF, "R8 pos stays");
        drive(0, 1, 0, 8'hFF, 1, 8'hFF, "R8 subtract from full");
        drive(1, 0, 0, 0, 0, 0, "R2 clear");
        drive(0, 1, 1, 8'hFF, 0, 8'hFF, "R8 neg step");
        drive(0, 1, 0, 8'hFF, 1, 8'hFF, "R8 neg saturate");
        drive(0, 0, 0, 8'h12, 0, 8'h34, "R3 hold after sat");

        for (int i = 0; i < 400; i++) begin
            bit rc = ($urandom % 23) == 0;
            bit re = ($urandom % 5) != 0;
            drive(rc, re, 1'($urandom), int'($urandom % 256), 1'($urandom),
                  int'($urandom % 256), "R7 random mix");
        end
        drive(0, 0, 0, 0, 0, 0, "R3 final hold");
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule